// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack and Skip

This block produces the instruction fetch address for a small 8-bit controller core with a 13-bit program counter. Each cycle the decoder gives it the class of the instruction at the current fetch address. The block then steps the counter, enters a subroutine, returns from one, or performs a bit-test skip. Subroutine entry saves the return address in an internal return stack of eight entries. The target address joins an 11-bit literal from the instruction with two page bits from a separate page latch register.

Any change of flow costs one extra cycle. The instruction fetched after a call, a return or a taken skip is discarded, and the block raises a flush strobe for that slot so that the core executes a NOP in its place. The stack is circular. A push onto a full stack replaces the oldest entry and pulses an overflow flag. A pop from an empty stack pulses an underflow flag.

Top module: `pcseq_top`

## Requirements
- R1: While reset is high and on the first cycle after it, fetch_addr is 0, flush is 0, both stack flags are 0, and the return stack is empty.
- R2: Instruction class 2'b00 (sequential), with flush low, makes fetch_addr one cycle later equal the old value plus 1 modulo 8192, with flush low. 8191 steps to 0.
- R3: Class 2'b01 (call) at address A, with flush low, gives fetch_addr A+1 with flush high one cycle later. One cycle after that, fetch_addr is {page_latch[4:3], imm}.
- R4: A call pushes A+1 (modulo 8192) onto the return stack.
- R5: Class 2'b10 (return) at address A, with flush low, gives fetch_addr A+1 with flush high one cycle later. One cycle after that, fetch_addr is the most recently pushed address that has not yet been popped.
- R6: Class 2'b11 (bit-test skip) with bit_val 0 behaves exactly like a sequential instruction, with no flush.
- R7: Class 2'b11 with bit_val 1 at address A gives fetch_addr A+1 with flush high, then A+2 (modulo 8192).
- R8: In a cycle where flush is high, op_class, imm, page_latch and bit_val are ignored. The stack is not touched, and the next fetch_addr is the redirect target of the preceding instruction.
- R9: The stack holds 8 return addresses in last-in-first-out order. A ninth outstanding push overwrites the oldest entry, and stk_ovf is high for the one cycle after that push.
- R10: A return on an empty stack redirects to address 0, leaves the stack empty, and stk_ovf stays low while stk_unf is high for the one cycle after that return.
- R11: stk_ovf and stk_unf are low in every cycle not named in R9 or R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 2 | Class of the instruction at fetch_addr: 00 sequential, 01 call, 10 return, 11 bit-test skip |
| imm | input | 11 | Call target literal, low address bits |
| page_latch | input | 8 | Page latch register; bits 4:3 form the upper two target bits |
| bit_val | input | 1 | Value of the bit tested by a skip |
| fetch_addr | output | 13 | Registered instruction fetch address |
| flush | output | 1 | Registered strobe: the instruction at fetch_addr is to be replaced by a NOP |
| stk_ovf | output | 1 | One-cycle pulse after a push onto a full stack |
| stk_unf | output | 1 | One-cycle pulse after a return on an empty stack |

## Verification
The hardest state to reach is a wrapped stack. Nine calls without returns fill all eight slots and then overwrite the oldest. Nine returns follow, and the order of the returned addresses must skip the overwritten entry before the final return underflows to address 0. The stimulus builds this with a chain of nested calls, each followed by its flush slot. The bench drives a return opcode into those flush slots so that any push or pop leaking from an ignored slot shifts every later return address. A call that lands on address 8191 followed by a sequential step covers the wrap of the counter. A long random mix then exercises call, return and skip against the bench's own model.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [1:0] {
    OP_SEQ  = 2'b00,
    OP_CALL = 2'b01,
    OP_RET  = 2'b10,
    OP_SKIP = 2'b11
  } op_e;
endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         ovf,
  output logic         unf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr, ptr_up, ptr_dn;
  logic [CW-1:0] cnt;
  logic          full, empty;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign ptr_up = (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign ptr_dn = (ptr == '0) ? PW'(DEPTH - 1) : ptr - 1'b1;
  assign rd_data = empty ? '0 : mem[ptr_dn];

  // storage array: write-only clocked port, no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= push && full;
      unf <= pop && empty;
      if (push) begin
        ptr <= ptr_up;
        if (!full) cnt <= cnt + 1'b1;
      end else if (pop && !empty) begin
        ptr <= ptr_dn;
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R9
  full_push_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (push && cnt == CW'(DEPTH)) |=> ovf);
  // R10
  empty_pop_unf_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && cnt == '0) |=> (unf && cnt == '0));
  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int LIT_W    = 11,
  parameter int LATCH_W  = 8,
  parameter int PAGE_LSB = 3
) (
  input  logic [PC_W-1:0]    pc,
  input  logic [PC_W-1:0]    pend,
  input  logic               fl,
  input  op_e                op,
  input  logic [LIT_W-1:0]   imm,
  input  logic [LATCH_W-1:0] latch,
  input  logic               bitv,
  input  logic [PC_W-1:0]    pop_data,
  output logic [PC_W-1:0]    pc_nxt,
  output logic [PC_W-1:0]    pend_nxt,
  output logic               fl_nxt,
  output logic               push,
  output logic               pop,
  output logic [PC_W-1:0]    push_data
);
  localparam int PAGE_W = PC_W - LIT_W;

  logic [PC_W-1:0] target, pc_inc, pc_inc2;

  generate
    if (PAGE_W > 0) begin : g_paged
      assign target = {latch[PAGE_LSB +: PAGE_W], imm};
    end else begin : g_flat
      assign target = imm[PC_W-1:0];
    end
  endgenerate

  assign pc_inc  = pc + PC_W'(1);
  assign pc_inc2 = pc + PC_W'(2);

  always_comb begin
    pc_nxt    = pc_inc;
    pend_nxt  = pend;
    fl_nxt    = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    push_data = pc_inc;
    if (fl) begin
      pc_nxt = pend;
    end else begin
      unique case (op)
        OP_CALL: begin
          push     = 1'b1;
          pend_nxt = target;
          fl_nxt   = 1'b1;
        end
        OP_RET: begin
          pop      = 1'b1;
          pend_nxt = pop_data;
          fl_nxt   = 1'b1;
        end
        OP_SKIP: begin
          if (bitv) begin
            pend_nxt = pc_inc2;
            fl_nxt   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int LIT_W    = 11,
  parameter int LATCH_W  = 8,
  parameter int PAGE_LSB = 3,
  parameter int DEPTH    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         op_class,
  input  logic [LIT_W-1:0]   imm,
  input  logic [LATCH_W-1:0] page_latch,
  input  logic               bit_val,
  output logic [PC_W-1:0]    fetch_addr,
  output logic               flush,
  output logic               stk_ovf,
  output logic               stk_unf
);
  logic [PC_W-1:0] pc_q, pend_q, pc_d, pend_d, push_data, pop_data;
  logic            fl_q, fl_d, push, pop;
  op_e             op;

  assign op = op_e'(op_class);

  pcseq_next #(
    .PC_W(PC_W), .LIT_W(LIT_W), .LATCH_W(LATCH_W), .PAGE_LSB(PAGE_LSB)
  ) u_next (
    .pc(pc_q), .pend(pend_q), .fl(fl_q), .op(op), .imm(imm),
    .latch(page_latch), .bitv(bit_val), .pop_data(pop_data),
    .pc_nxt(pc_d), .pend_nxt(pend_d), .fl_nxt(fl_d),
    .push(push), .pop(pop), .push_data(push_data)
  );

  pcseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wr_data(push_data), .rd_data(pop_data), .ovf(stk_ovf), .unf(stk_unf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      pend_q <= '0;
      fl_q   <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      pend_q <= pend_d;
      fl_q   <= fl_d;
    end
  end

  assign fetch_addr = pc_q;
  assign flush      = fl_q;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && op_class == 2'b00) |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1) && !flush));
  // R3
  call_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && op_class == 2'b01) |=> flush);
  // R6
  skip_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && op_class == 2'b11 && !bit_val) |=> !flush);
  // R8
  single_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);
endmodule

// File: tb/sim_pcseq_top.sv
module sim_pcseq_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [1:0]  op_class;
  logic [10:0] imm;
  logic [7:0]  page_latch;
  logic        bit_val;
  logic [12:0] fetch_addr;
  logic        flush, stk_ovf, stk_unf;

  pcseq_top u0 (
    .clk(clk), .rst(rst), .op_class(op_class), .imm(imm),
    .page_latch(page_latch), .bit_val(bit_val), .fetch_addr(fetch_addr),
    .flush(flush), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  typedef struct {
    logic [12:0] a;
    logic        f, o, u;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;

  // reference model state
  logic [12:0] m_pc = '0, m_pend = '0;
  logic        m_fl = 1'b0;
  logic [12:0] m_stk [8];
  int          m_ptr = 0, m_cnt = 0;

  task automatic compare(exp_t e);
    n_chk++;
    if (fetch_addr !== e.a || flush !== e.f || stk_ovf !== e.o || stk_unf !== e.u) begin
      n_bad++;
      $display("FAIL %s: got addr=%0d flush=%0b ovf=%0b unf=%0b, expected addr=%0d flush=%0b ovf=%0b unf=%0b",
               e.tag, fetch_addr, flush, stk_ovf, stk_unf, e.a, e.f, e.o, e.u);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  // drive one instruction slot and queue what the design must show after the edge
  task automatic step(input logic [1:0] op, input logic [10:0] im,
                      input logic [7:0] lt, input logic b);
    exp_t e;
    op_class = op; imm = im; page_latch = lt; bit_val = b;
    e.o = 1'b0; e.u = 1'b0; e.f = 1'b0;
    if (m_fl) begin
      e.tag = "R8 redirect";
      m_pc  = m_pend;
      m_fl  = 1'b0;
    end else begin
      case (op)
        2'b00: e.tag = "R2 R11 sequential";
        2'b01: begin
          e.tag = "R3 call";
          m_stk[m_ptr] = m_pc + 13'd1;
          m_ptr = (m_ptr + 1) % 8;
          if (m_cnt == 8) begin e.o = 1'b1; e.tag = "R9 overflow"; end
          else m_cnt++;
          m_pend = {lt[4:3], im};
          m_fl = 1'b1;
        end
        2'b10: begin
          e.tag = "R5 R4 return";
          if (m_cnt == 0) begin
            e.u = 1'b1; e.tag = "R10 underflow"; m_pend = '0;
          end else begin
            m_ptr = (m_ptr + 7) % 8;
            m_pend = m_stk[m_ptr];
            m_cnt--;
          end
          m_fl = 1'b1;
        end
        default: begin
          if (b) begin
            e.tag = "R7 skip taken"; m_pend = m_pc + 13'd2; m_fl = 1'b1;
          end else e.tag = "R6 skip not taken";
        end
      endcase
      m_pc = m_pc + 13'd1;
    end
    e.a = m_pc; e.f = m_fl;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got no completion, expected end of run");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; op_class = 2'b00; imm = '0; page_latch = '0; bit_val = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (fetch_addr !== 13'd0 || flush !== 1'b0 || stk_ovf !== 1'b0 || stk_unf !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got addr=%0d flush=%0b ovf=%0b unf=%0b, expected 0 0 0 0",
               fetch_addr, flush, stk_ovf, stk_unf);
    end
    rst = 1'b0;
    // R1 R10: stack empty after reset, so a return underflows to 0
    step(2'b10, '0, '0, 1'b0);
    step(2'b00, '0, '0, 1'b0);
    repeat (3) step(2'b00, '0, '0, 1'b0);
    step(2'b11, '0, '0, 1'b0);          // R6
    step(2'b11, '0, '0, 1'b1);          // R7
    step(2'b10, 11'h155, 8'hFF, 1'b1);  // R8: ignored return in the flush slot
    // R3 target 8191 from page bits 11 and literal 2047, then R2 wrap
    step(2'b01, 11'h7FF, 8'b0001_1000, 1'b0);
    step(2'b01, 11'h001, 8'h00, 1'b0);  // R8: ignored call
    step(2'b00, '0, '0, 1'b0);
    step(2'b00, '0, '0, 1'b0);
    step(2'b10, '0, '0, 1'b0);          // R5 R4
    step(2'b00, '0, '0, 1'b0);
    // R9: nine nested calls, ignored returns in every flush slot
    for (int i = 0; i < 9; i++) begin
      step(2'b01, 11'(100 * i + 7), 8'(i << 3), 1'b0);
      step(2'b10, '0, '0, 1'b0);
    end
    // R9 R10: nine returns, the oldest was overwritten, the last underflows
    for (int i = 0; i < 9; i++) begin
      step(2'b10, '0, '0, 1'b0);
      step(2'b01, 11'h3, 8'hFF, 1'b1);
    end
    for (int i = 0; i < 400; i++) begin
      step(2'($urandom_range(0, 3)), 11'($urandom), 8'($urandom), 1'($urandom));
    end
    step(2'b00, '0, '0, 1'b0);
    step(2'b00, '0, '0, 1'b0);
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule